// File: doc/BRIEF.md
# Low-Power Bus and Local Wake-Up Recogniser

This block sits behind the low-power receiver of a bus transceiver and decides when a wake-up has truly been requested while the part is resting. It watches two asynchronous levels: a dominant/recessive indication from the bus receiver and the level on a local wake pin. It resynchronises both to its clock and searches the bus for a dominant, recessive, dominant, recessive pattern in which every phase lasts long enough. It also filters the local pin so that a level change counts only once it has held for a minimum time.

Each recognised request leaves the block as a one-cycle event. A separate one-cycle strobe tells the mode logic that the local wake-up flag may be set, which is only allowed while the power-up flag is clear. A steady output selects the direction of the current source on the wake pin, following the last filtered level. Detection runs only while the mode logic reports a low-power mode and no undervoltage hold-off is active. All minimum durations are parameters counted in clock cycles.

Top module: `wake_detect`

## Requirements
- R1: A remote event pulses once when the synchronised bus shows a dominant phase of at least T_DOM_CYC cycles, a recessive phase of at least T_REC_CYC cycles, a second dominant phase of at least T_DOM_CYC cycles, and then T_REC_CYC recessive cycles; a phase of exactly the minimum length is accepted.
- R2: A dominant phase shorter than T_DOM_CYC cycles, first or second, discards the pattern so far and the search restarts from idle with no remote event.
- R3: A recessive gap shorter than T_REC_CYC cycles discards the pattern so far, and the dominant phase that ends that gap is counted as the first dominant phase of a new pattern.
- R4: A change of the synchronised wake pin level in either direction that holds for T_WAKE_CYC consecutive cycles gives one local event; a level held for exactly T_WAKE_CYC cycles is accepted.
- R5: A wake pin excursion shorter than T_WAKE_CYC cycles gives no local event and leaves the pull direction unchanged.
- R6: The pull output is 1 (pull-up) after the wake pin has been filtered as high and 0 (pull-down) after it has been filtered as low; it follows filtered changes even while detection is disabled.
- R7: Events are produced only while low_power is 1 and detect_block is 0; while disabled no event appears and the bus search returns to idle, so a phase seen before disabling never joins a pattern after re-enabling.
- R8: The local flag strobe pulses together with a local event only when pwrup_flag was 0 in the cycle the event was decided; otherwise the event still pulses and the strobe stays 0.
- R9: After reset all three event outputs and the pull output are 0, and every event lasts exactly one cycle.
- R10: A remote event and a local event that complete in the same cycle are both reported in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_dom_raw | input | 1 | Asynchronous bus indication from the low-power receiver, 1 = dominant |
| wake_pin_raw | input | 1 | Asynchronous level of the local wake pin |
| low_power | input | 1 | 1 while the mode is standby, go-to-sleep or sleep |
| detect_block | input | 1 | 1 while the undervoltage waiting time runs |
| pwrup_flag | input | 1 | Current state of the power-up flag |
| remote_wake | output | 1 | One-cycle event: valid bus wake-up pattern seen |
| local_wake | output | 1 | One-cycle event: filtered wake pin change |
| local_flag_set | output | 1 | One-cycle strobe: set the local wake-up flag |
| wake_pull_up | output | 1 | Current source direction on the wake pin, 1 = pull-up |

## Verification
The bus pattern search and the wake pin filter run side by side, so both can finish in one clock cycle. The bench provokes this by lining up the start of the final recessive phase with a wake pin edge placed exactly the difference of the two minimum times earlier, so that both inputs reach their last qualifying sample together. It judges the result by requiring one remote event, one local event and one cycle in which both were high at once.

// File: rtl/wake_det_pkg.sv
// Package: shared types for the wake-up recogniser.
// Assumes nothing beyond the standard language.
package wake_det_pkg;

    // Steps of the bus wake-up pattern search.
    typedef enum logic [2:0] {
        RW_IDLE  = 3'd0,
        RW_DOM_A = 3'd1,
        RW_REC_A = 3'd2,
        RW_DOM_B = 3'd3,
        RW_REC_B = 3'd4
    } rw_step_e;

    // Larger of two durations, used to size a shared phase counter.
    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wake_det_sync.sv
// Module: multi-stage resynchroniser for one asynchronous level.
// Assumes STAGES >= 1; the reset value is loaded into every stage.
module wake_det_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage: capture the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stages: pass the level down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wake_det_remote.sv
// Module: bus wake-up pattern search.
// Looks for dominant, recessive, dominant, recessive phases, each at least
// its minimum length in cycles. A short dominant phase returns to idle; a
// short recessive gap makes the dominant that ended it the new first phase.
// Assumes dom is already synchronous and T_REC >= 2, T_DOM >= 1.
module wake_det_remote
    import wake_det_pkg::*;
#(
    parameter int unsigned T_DOM = 4,
    parameter int unsigned T_REC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dom,
    output logic fire_o
);

    localparam int unsigned CNT_MAX = max_of(T_DOM, T_REC);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DOM_MIN = CNT_W'(T_DOM);
    localparam logic [CNT_W-1:0] REC_MIN = CNT_W'(T_REC);
    localparam logic [CNT_W-1:0] SAT     = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    rw_step_e         step_q, step_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             fire_d;

    // Saturating increment of the current phase length.
    assign cnt_inc = (cnt_q == SAT) ? cnt_q : cnt_q + ONE;

    // Next step of the pattern search.
    always_comb begin
        step_d = step_q;
        cnt_d  = cnt_q;
        fire_d = 1'b0;
        unique case (step_q)
            RW_IDLE: begin
                if (dom) begin
                    step_d = RW_DOM_A;
                    cnt_d  = ONE;
                end
            end
            RW_DOM_A, RW_DOM_B: begin
                if (dom) begin
                    cnt_d = cnt_inc;
                end else if (cnt_q >= DOM_MIN) begin
                    step_d = (step_q == RW_DOM_A) ? RW_REC_A : RW_REC_B;
                    cnt_d  = ONE;
                end else begin
                    step_d = RW_IDLE;
                    cnt_d  = '0;
                end
            end
            RW_REC_A: begin
                if (!dom) begin
                    cnt_d = cnt_inc;
                end else if (cnt_q >= REC_MIN) begin
                    step_d = RW_DOM_B;
                    cnt_d  = ONE;
                end else begin
                    step_d = RW_DOM_A;
                    cnt_d  = ONE;
                end
            end
            RW_REC_B: begin
                if (!dom) begin
                    if (cnt_inc >= REC_MIN) begin
                        step_d = RW_IDLE;
                        cnt_d  = '0;
                        fire_d = 1'b1;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end else begin
                    step_d = RW_DOM_A;
                    cnt_d  = ONE;
                end
            end
            default: begin
                step_d = RW_IDLE;
                cnt_d  = '0;
            end
        endcase
    end

    // State, phase counter and the registered event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= RW_IDLE;
            cnt_q  <= '0;
            fire_o <= 1'b0;
        end else if (!en) begin
            step_q <= RW_IDLE;
            cnt_q  <= '0;
            fire_o <= 1'b0;
        end else begin
            step_q <= step_d;
            cnt_q  <= cnt_d;
            fire_o <= fire_d;
        end
    end

endmodule

// File: rtl/wake_det_local.sv
// Module: wake pin level filter.
// A level differing from the accepted level for T_WAKE consecutive cycles
// becomes the accepted level; this drives the pull direction at all times
// and raises an event only while enabled. Assumes T_WAKE >= 2.
module wake_det_local #(
    parameter int unsigned T_WAKE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl,
    input  logic pwrup,
    output logic evt_o,
    output logic flag_o,
    output logic pull_o
);

    localparam int unsigned CNT_W = $clog2(T_WAKE + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(T_WAKE);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             stable_q;
    logic [CNT_W-1:0] cnt_q;
    logic             differs;

    assign differs = (lvl != stable_q);

    // Count cycles of a differing level and accept it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            cnt_q    <= '0;
            evt_o    <= 1'b0;
            flag_o   <= 1'b0;
        end else begin
            evt_o  <= 1'b0;
            flag_o <= 1'b0;
            if (!differs) begin
                cnt_q <= '0;
            end else if ((cnt_q + ONE) >= LIM) begin
                stable_q <= lvl;
                cnt_q    <= '0;
                evt_o    <= en;
                flag_o   <= en & ~pwrup;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    assign pull_o = stable_q;

endmodule

// File: rtl/wake_detect.sv
// Module: top of the wake-up recogniser.
// Resynchronises the bus and wake pin levels, runs the bus pattern search
// and the wake pin filter in parallel, and gates both with the mode inputs.
// Assumes low_power, detect_block and pwrup_flag are synchronous to clk.
module wake_detect #(
    parameter int unsigned T_DOM_CYC   = 4,
    parameter int unsigned T_REC_CYC   = 5,
    parameter int unsigned T_WAKE_CYC  = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_dom_raw,
    input  logic wake_pin_raw,
    input  logic low_power,
    input  logic detect_block,
    input  logic pwrup_flag,
    output logic remote_wake,
    output logic local_wake,
    output logic local_flag_set,
    output logic wake_pull_up
);

    logic bus_dom_s;
    logic wake_lvl_s;
    logic det_en;

    // Detection is live only in a low-power mode outside the hold-off.
    assign det_en = low_power & ~detect_block;

    wake_det_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_dom_raw),
        .q     (bus_dom_s)
    );

    wake_det_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wake_pin_raw),
        .q     (wake_lvl_s)
    );

    wake_det_remote #(.T_DOM(T_DOM_CYC), .T_REC(T_REC_CYC)) u_remote (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (det_en),
        .dom    (bus_dom_s),
        .fire_o (remote_wake)
    );

    wake_det_local #(.T_WAKE(T_WAKE_CYC)) u_local (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (det_en),
        .lvl    (wake_lvl_s),
        .pwrup  (pwrup_flag),
        .evt_o  (local_wake),
        .flag_o (local_flag_set),
        .pull_o (wake_pull_up)
    );

endmodule

// File: rtl/wake_detect_chk.sv
// Module: property checker for wake_detect, attached by bind.
// Assumes the synchronous active-low reset of the top module.
module wake_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic low_power,
    input logic detect_block,
    input logic pwrup_flag,
    input logic remote_wake,
    input logic local_wake,
    input logic local_flag_set,
    input logic wake_pull_up
);

    p_remote_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake |=> !remote_wake);

    p_local_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |=> !local_wake);

    p_remote_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake |-> $past(low_power && !detect_block));

    p_local_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |-> $past(low_power && !detect_block));

    p_flag_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        local_flag_set |-> (local_wake && !$past(pwrup_flag)));

    p_pull_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |-> !$stable(wake_pull_up));

endmodule

bind wake_detect wake_detect_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .low_power      (low_power),
    .detect_block   (detect_block),
    .pwrup_flag     (pwrup_flag),
    .remote_wake    (remote_wake),
    .local_wake     (local_wake),
    .local_flag_set (local_flag_set),
    .wake_pull_up   (wake_pull_up)
);

// File: tb/wake_detect_bench.sv
// Bench: table-driven bus patterns, then directed wake pin, gating,
// reset and same-cycle cases. Uses T_DOM=4, T_REC=5, T_WAKE=8 cycles.
module wake_detect_bench;

    localparam int TD = 4;
    localparam int TR = 5;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_dom_raw = 1'b0;
    logic wake_pin_raw = 1'b0;
    logic low_power = 1'b1;
    logic detect_block = 1'b0;
    logic pwrup_flag = 1'b0;
    logic remote_wake, local_wake, local_flag_set, wake_pull_up;

    int total = 0;
    int bad = 0;
    int n_rem = 0, n_loc = 0, n_flag = 0, n_both = 0;

    always #10 clk = ~clk;

    wake_detect #(.T_DOM_CYC(TD), .T_REC_CYC(TR), .T_WAKE_CYC(TW), .SYNC_STAGES(2)) u_wake_detect (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_dom_raw    (bus_dom_raw),
        .wake_pin_raw   (wake_pin_raw),
        .low_power      (low_power),
        .detect_block   (detect_block),
        .pwrup_flag     (pwrup_flag),
        .remote_wake    (remote_wake),
        .local_wake     (local_wake),
        .local_flag_set (local_flag_set),
        .wake_pull_up   (wake_pull_up)
    );

    // Event counters sampled between edges.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            if (remote_wake) n_rem++;
            if (local_wake) n_loc++;
            if (local_flag_set) n_flag++;
            if (remote_wake && local_wake) n_both++;
        end
    end

    // Table: {first dominant, gap, second dominant, expected events}.
    localparam logic [31:0] VEC [0:6] = '{
        {8'd4,  8'd5,  8'd4,  8'd1},   // R1 exact minimum phases
        {8'd10, 8'd12, 8'd6,  8'd1},   // R1 long phases
        {8'd3,  8'd5,  8'd4,  8'd0},   // R2 short first dominant
        {8'd4,  8'd5,  8'd3,  8'd0},   // R2 short second dominant
        {8'd4,  8'd4,  8'd4,  8'd0},   // R3 gap one cycle short
        {8'd6,  8'd2,  8'd5,  8'd0},   // R3 very short gap
        {8'd1,  8'd1,  8'd1,  8'd0}    // R2 single-cycle glitches
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_bus(input logic v, input int n);
        bus_dom_raw = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_wake(input logic v, input int n);
        wake_pin_raw = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_rem = 0; n_loc = 0; n_flag = 0; n_both = 0;
    endtask

    // Drop the mode for a moment so the bus search restarts (R7).
    task automatic rearm();
        low_power = 1'b0;
        repeat (2) @(negedge clk);
        low_power = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // Reset state (R9, R6).
        check("R9 remote after reset", int'(remote_wake), 0);
        check("R9 local after reset", int'(local_wake), 0);
        check("R9 flag after reset", int'(local_flag_set), 0);
        check("R6 pull after reset", int'(wake_pull_up), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Table of bus patterns (R1, R2, R3).
        for (int i = 0; i < 7; i++) begin
            clear_counts();
            hold_bus(1'b1, int'(VEC[i][31:24]));
            hold_bus(1'b0, int'(VEC[i][23:16]));
            hold_bus(1'b1, int'(VEC[i][15:8]));
            hold_bus(1'b0, 20);
            check($sformatf("R1/R2/R3 bus vector %0d", i), n_rem, int'(VEC[i][7:0]));
            rearm();
        end

        // R3: short gap restarts with the ending dominant as first phase.
        clear_counts();
        hold_bus(1'b1, 4); hold_bus(1'b0, 2); hold_bus(1'b1, 4);
        hold_bus(1'b0, 5); hold_bus(1'b1, 4); hold_bus(1'b0, 20);
        check("R3 restart counts ending dominant", n_rem, 1);
        rearm();

        // R7: blocked detection and non-low-power mode.
        clear_counts();
        detect_block = 1'b1;
        hold_bus(1'b1, 6); hold_bus(1'b0, 6); hold_bus(1'b1, 6); hold_bus(1'b0, 20);
        detect_block = 1'b0;
        check("R7 blocked bus pattern", n_rem, 0);
        // R7: first phase before disabling must not join a later one.
        clear_counts();
        hold_bus(1'b1, 6); hold_bus(1'b0, 6);
        rearm();
        hold_bus(1'b1, 6); hold_bus(1'b0, 20);
        check("R7 search reset by disable", n_rem, 0);

        // R4, R6, R8: rising then falling filtered changes.
        clear_counts();
        hold_wake(1'b1, 14);
        check("R4 rising local event", n_loc, 1);
        check("R8 flag with power-up clear", n_flag, 1);
        check("R6 pull-up after high", int'(wake_pull_up), 1);
        clear_counts();
        hold_wake(1'b0, 14);
        check("R4 falling local event", n_loc, 1);
        check("R6 pull-down after low", int'(wake_pull_up), 0);

        // R5: glitch one cycle short.
        clear_counts();
        wake_pin_raw = 1'b1;
        repeat (TW - 1) @(negedge clk);
        check("R5 pull unchanged during glitch", int'(wake_pull_up), 0);
        hold_wake(1'b0, 14);
        check("R5 short glitch ignored", n_loc, 0);
        check("R5 pull unchanged after glitch", int'(wake_pull_up), 0);

        // R4 boundary: exactly TW cycles high, then low.
        clear_counts();
        hold_wake(1'b1, TW);
        hold_wake(1'b0, 14);
        check("R4 exact filter time both edges", n_loc, 2);

        // R8: power-up flag set suppresses the flag strobe only.
        clear_counts();
        pwrup_flag = 1'b1;
        hold_wake(1'b1, 14);
        check("R8 event with power-up set", n_loc, 1);
        check("R8 no flag with power-up set", n_flag, 0);
        pwrup_flag = 1'b0;

        // R7, R6: filter tracks while disabled but reports nothing.
        clear_counts();
        low_power = 1'b0;
        hold_wake(1'b0, 14);
        check("R7 no local event when disabled", n_loc, 0);
        check("R6 pull follows while disabled", int'(wake_pull_up), 0);
        low_power = 1'b1;
        @(negedge clk);

        // R10: both searches complete in the same cycle.
        clear_counts();
        hold_bus(1'b1, 6); hold_bus(1'b0, 6);
        bus_dom_raw = 1'b1;
        repeat (3) @(negedge clk);
        wake_pin_raw = 1'b1;
        repeat (TW - TR) @(negedge clk);
        hold_bus(1'b0, 20);
        check("R10 remote in joint case", n_rem, 1);
        check("R10 local in joint case", n_loc, 1);
        check("R10 same-cycle events", n_both, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule